// File: doc/BRIEF.md
# Interframe Gap Deferral Timer with Post-Transmit Carrier Blinding

This block decides when a half-duplex MAC transmitter may start its next frame. It watches carrier sense, the transmitter's own busy flag and a bit-time tick, and drives `defer_ok` when a full interframe gap has passed with the medium quiet. Durations are counted in bit-time ticks, so the same block serves any line rate whose tick is supplied.

After the station's own transmission ends, carrier sense is masked for a fixed blinding period. This lets the station ignore echoes and the collision-detect test pulse from its own transceiver. The blinding period is never restarted. In two-part mode the gap then splits into an open window that restarts on carrier and a tail that runs to completion whatever carrier does. With two-part mode disabled, carrier at any point after blinding restarts the whole gap.

The controller has six states:
- `ST_TX`: own transmission in progress.
- `ST_BLIND`: carrier masked.
- `ST_OPEN`: carrier restarts the gap.
- `ST_TAIL`: carrier ignored.
- `ST_BUSY`: carrier present, waiting for it to drop.
- `ST_CLEAR`: deferral complete.

Transitions:
- Any state goes to TX when `tx_busy` is high.
- TX goes to BLIND when `tx_busy` falls.
- BLIND goes to OPEN after `BLIND_TICKS` ticks.
- OPEN goes to BUSY on carrier.
- OPEN goes to TAIL at `PART1_TICKS`, in two-part mode only.
- OPEN goes to CLEAR at `GAP_TICKS`.
- TAIL goes to CLEAR at `GAP_TICKS`.
- BUSY goes to OPEN when carrier drops.
- CLEAR goes to BUSY on carrier.

Top module: `ifg_defer_timer`

## Requirements
- R1: Reset puts the block in the open window with a zero count and `defer_ok` low. With no carrier, no transmission and a tick every cycle, `defer_ok` rises after the 96th clock edge following reset release.
- R2: `defer_ok` is high only when deferral is complete and `tx_busy` is low. It falls in the same cycle that `tx_busy` rises, without waiting for a clock edge.
- R3: Consider the first clock edge that samples `tx_busy` low after a transmission. With a tick every cycle and no carrier, `defer_ok` rises after the GAP_TICKS-th (96th) edge following it.
- R4: Carrier during the first BLIND_TICKS (40) ticks after the station's own transmission has no effect on when `defer_ok` rises, in either mode. Carrier never restarts the blinding period.
- R5: In the open window, carrier restarts the gap. Carrier sampled at edge n sends the block to BUSY. The first edge that samples carrier low clears the count. `defer_ok` then rises GAP_TICKS ticks later, and carrier takes priority over a tick on the same edge.
- R6: With `two_part_dis` low, once PART1_TICKS (60) ticks of the gap have counted, carrier is ignored until `defer_ok` rises.
- R7: With `two_part_dis` high, carrier at any point after blinding restarts the full gap as in R5. The mode is sampled on the tick that would end the open window.
- R8: Carrier while deferral is complete drops `defer_ok` after the next clock edge and requires a fresh full gap after carrier falls.
- R9: Only clock edges with `bit_tick` high advance the gap count. Cycles without a tick extend every window.
- R10: `tx_busy` rising during a gap abandons it. When `tx_busy` falls again, timing restarts from the blinding period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crs | input | 1 | Carrier sense from the medium |
| tx_busy | input | 1 | Own transmission in progress |
| two_part_dis | input | 1 | High bypasses two-part deferral |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| defer_ok | output | 1 | Transmission permitted |

## Verification
The bench aims at the window edges:
- Carrier on the last blinded tick must be ignored; a design that blinded one tick short would restart the gap.
- Carrier on the first open tick must restart the gap; a design with an off-by-one window would let it through.
- Carrier sampled on the very tick that closes the first window must still restart the gap. A design that let the tick win over carrier would transmit 61 ticks early.
- With two-part mode disabled, carrier late in the gap must restart it; a design that kept the tail would transmit into a busy medium.
- A transmission during a gap must restart the blinding period; a design that failed to would permit transmission too soon.
- Random phases with irregular ticks compare every cycle against a bench model, which catches counting on edges without a tick.

// File: rtl/ifg_defer_pkg.sv
package ifg_defer_pkg;

    typedef enum logic [2:0] {
        ST_TX    = 3'd0,
        ST_BLIND = 3'd1,
        ST_OPEN  = 3'd2,
        ST_TAIL  = 3'd3,
        ST_BUSY  = 3'd4,
        ST_CLEAR = 3'd5
    } defer_st_e;

endpackage

// File: rtl/ifg_tick_counter.sv
module ifg_tick_counter #(
    parameter int CNT_W   = 7,
    parameter int MAX_VAL = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(MAX_VAL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ifg_defer_fsm.sv
module ifg_defer_fsm
    import ifg_defer_pkg::*;
#(
    parameter int CNT_W       = 7,
    parameter int BLIND_TICKS = 40,
    parameter int PART1_TICKS = 60,
    parameter int GAP_TICKS   = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             crs,
    input  logic             tx_busy,
    input  logic             two_part_dis,
    input  logic             bit_tick,
    input  logic [CNT_W-1:0] cnt,
    output defer_st_e        st,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             defer_ok
);
    localparam logic [CNT_W-1:0] LAST_BLIND = CNT_W'(BLIND_TICKS - 1);
    localparam logic [CNT_W-1:0] LAST_PART1 = CNT_W'(PART1_TICKS - 1);
    localparam logic [CNT_W-1:0] LAST_GAP   = CNT_W'(GAP_TICKS - 1);

    defer_st_e st_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_OPEN;
        end else begin
            st <= st_nx;
        end
    end

    // next state and counter control
    always_comb begin
        st_nx   = st;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (tx_busy) begin
            st_nx   = ST_TX;
            cnt_clr = 1'b1;
        end else begin
            unique case (st)
                ST_TX: begin
                    st_nx   = ST_BLIND;
                    cnt_clr = 1'b1;
                end
                ST_BLIND: begin
                    if (bit_tick) begin
                        cnt_inc = 1'b1;
                        if (cnt == LAST_BLIND) st_nx = ST_OPEN;
                    end
                end
                ST_OPEN: begin
                    if (crs) begin
                        st_nx   = ST_BUSY;
                        cnt_clr = 1'b1;
                    end else if (bit_tick) begin
                        cnt_inc = 1'b1;
                        if (cnt == LAST_GAP) begin
                            st_nx = ST_CLEAR;
                        end else if (!two_part_dis && cnt == LAST_PART1) begin
                            st_nx = ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    if (bit_tick) begin
                        cnt_inc = 1'b1;
                        if (cnt == LAST_GAP) st_nx = ST_CLEAR;
                    end
                end
                ST_BUSY: begin
                    if (!crs) begin
                        st_nx   = ST_OPEN;
                        cnt_clr = 1'b1;
                    end
                end
                ST_CLEAR: begin
                    if (crs) begin
                        st_nx   = ST_BUSY;
                        cnt_clr = 1'b1;
                    end
                end
                default: begin
                    st_nx   = ST_OPEN;
                    cnt_clr = 1'b1;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        defer_ok = (st == ST_CLEAR) && !tx_busy;
    end
endmodule

// File: rtl/ifg_defer_timer.sv
module ifg_defer_timer
    import ifg_defer_pkg::*;
#(
    parameter int BLIND_TICKS = 40,
    parameter int PART1_TICKS = 60,
    parameter int GAP_TICKS   = 96
) (
    input  logic clk,
    input  logic rst_n,
    input  logic crs,
    input  logic tx_busy,
    input  logic two_part_dis,
    input  logic bit_tick,
    output logic defer_ok
);
    localparam int CNT_W = $clog2(GAP_TICKS + 1);

    defer_st_e        st;
    logic             cnt_clr;
    logic             cnt_inc;
    logic [CNT_W-1:0] cnt;

    ifg_tick_counter #(
        .CNT_W  (CNT_W),
        .MAX_VAL(GAP_TICKS)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .cnt  (cnt)
    );

    ifg_defer_fsm #(
        .CNT_W      (CNT_W),
        .BLIND_TICKS(BLIND_TICKS),
        .PART1_TICKS(PART1_TICKS),
        .GAP_TICKS  (GAP_TICKS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .crs         (crs),
        .tx_busy     (tx_busy),
        .two_part_dis(two_part_dis),
        .bit_tick    (bit_tick),
        .cnt         (cnt),
        .st          (st),
        .cnt_clr     (cnt_clr),
        .cnt_inc     (cnt_inc),
        .defer_ok    (defer_ok)
    );
endmodule

// File: rtl/ifg_defer_chk.sv
module ifg_defer_chk
    import ifg_defer_pkg::*;
#(
    parameter int CNT_W       = 7,
    parameter int BLIND_TICKS = 40,
    parameter int PART1_TICKS = 60,
    parameter int GAP_TICKS   = 96
) (
    input logic             clk,
    input logic             rst_n,
    input logic             crs,
    input logic             tx_busy,
    input logic             defer_ok,
    input defer_st_e        st,
    input logic [CNT_W-1:0] cnt
);
    // R10
    tx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> !defer_ok);

    // R3
    full_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CLEAR) |-> (cnt == CNT_W'(GAP_TICKS)));

    // R6
    tail_after_part1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TAIL) |-> (cnt >= CNT_W'(PART1_TICKS)));

    // R4
    blind_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BLIND) |-> (cnt < CNT_W'(BLIND_TICKS)));

    // R4
    blind_only_after_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BLIND && $past(st) != ST_BLIND) |-> ($past(st) == ST_TX));

    // R5
    busy_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY) |-> (cnt == '0));

    // R8
    carrier_revokes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CLEAR && crs && !tx_busy) |=> !defer_ok);
endmodule

bind ifg_defer_timer ifg_defer_chk #(
    .CNT_W      (CNT_W),
    .BLIND_TICKS(BLIND_TICKS),
    .PART1_TICKS(PART1_TICKS),
    .GAP_TICKS  (GAP_TICKS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .crs     (crs),
    .tx_busy (tx_busy),
    .defer_ok(defer_ok),
    .st      (st),
    .cnt     (cnt)
);

// File: tb/ifg_defer_timer_bench.sv
module ifg_defer_timer_bench;
    localparam int BLIND = 40;
    localparam int PART1 = 60;
    localparam int GAP   = 96;

    localparam int P_TX = 0, P_BLIND = 1, P_OPEN = 2, P_TAIL = 3, P_BUSY = 4, P_CLEAR = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic crs = 1'b0;
    logic tx_busy = 1'b0;
    logic two_part_dis = 1'b0;
    logic bit_tick = 1'b0;
    logic defer_ok;

    int checks = 0;
    int failures = 0;
    int m_ph = P_OPEN;
    int m_n = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ifg_defer_timer #(
        .BLIND_TICKS(BLIND),
        .PART1_TICKS(PART1),
        .GAP_TICKS  (GAP)
    ) u_ifg_defer_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .crs         (crs),
        .tx_busy     (tx_busy),
        .two_part_dis(two_part_dis),
        .bit_tick    (bit_tick),
        .defer_ok    (defer_ok)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // bench reference model, advanced once per clock edge with the inputs it samples
    task automatic model_step(input bit c, input bit t, input bit d, input bit k);
        if (t) begin
            m_ph = P_TX; m_n = 0;
        end else begin
            case (m_ph)
                P_TX:    begin m_ph = P_BLIND; m_n = 0; end
                P_BLIND: if (k) begin m_n++; if (m_n == BLIND) m_ph = P_OPEN; end
                P_OPEN: begin
                    if (c) begin
                        m_ph = P_BUSY; m_n = 0;
                    end else if (k) begin
                        m_n++;
                        if (m_n == GAP) m_ph = P_CLEAR;
                        else if (!d && m_n == PART1) m_ph = P_TAIL;
                    end
                end
                P_TAIL:  if (k) begin m_n++; if (m_n == GAP) m_ph = P_CLEAR; end
                P_BUSY:  if (!c) begin m_ph = P_OPEN; m_n = 0; end
                default: if (c) begin m_ph = P_BUSY; m_n = 0; end
            endcase
        end
    endtask

    function automatic bit model_ok(input bit t);
        return (m_ph == P_CLEAR) && !t;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; crs = 1'b0; tx_busy = 1'b0; bit_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_ph = P_OPEN; m_n = 0;
    endtask

    // One transmission, then count edges (k) after the edge that samples tx low.
    // Carrier is high for k in [lo,hi]; tx_busy pulses for one edge at k == abort_k.
    task automatic measure(input string req, input bit dis, input int lo, input int hi,
                           input int abort_k, input int exp_k);
        int first;
        first = -1;
        bit_tick = 1'b1;
        @(negedge clk);
        tx_busy = 1'b1; crs = 1'b0; two_part_dis = dis;
        @(negedge clk);
        tx_busy = 1'b0;
        @(negedge clk);
        for (int k = 1; k <= 260; k++) begin
            crs = (k >= lo && k <= hi);
            tx_busy = (k == abort_k);
            @(negedge clk);
            if (defer_ok && first < 0) first = k;
        end
        crs = 1'b0; tx_busy = 1'b0;
        check(req, first, exp_k);
    endtask

    initial begin
        int first;
        do_reset();
        // R1: reset state
        check("R1 reset defer_ok", int'(defer_ok), 0);
        bit_tick = 1'b1;
        first = -1;
        for (int k = 1; k <= 120; k++) begin
            @(negedge clk);
            if (defer_ok && first < 0) first = k;
        end
        check("R1 first gap after reset", first, 96);

        // R2: tx_busy gates defer_ok without a clock edge
        tx_busy = 1'b1;
        #1;
        check("R2 combinational gate", int'(defer_ok), 0);
        @(negedge clk);
        tx_busy = 1'b0;

        measure("R3 quiet gap", 1'b0, 1000, 0, -1, 96);
        measure("R4 carrier in blinding", 1'b0, 1, 40, -1, 96);
        measure("R4 blinding in bypass mode", 1'b1, 5, 30, -1, 96);
        measure("R5 carrier on first open tick", 1'b0, 41, 41, -1, 138);
        measure("R5 carrier beats closing tick", 1'b0, 60, 60, -1, 157);
        measure("R6 carrier in tail ignored", 1'b0, 61, 80, -1, 96);
        measure("R7 bypass carrier restarts", 1'b1, 70, 70, -1, 167);
        measure("R7 bypass late carrier", 1'b1, 95, 95, -1, 192);
        measure("R10 tx during gap restarts blinding", 1'b0, 1000, 0, 50, 147);

        // R8: carrier while clear
        @(negedge clk);
        crs = 1'b1;
        @(negedge clk);
        check("R8 carrier revokes", int'(defer_ok), 0);
        crs = 1'b0;
        first = -1;
        for (int k = 1; k <= 120; k++) begin
            @(negedge clk);
            if (defer_ok && first < 0) first = k;
        end
        check("R8 fresh gap after carrier", first, 97);

        // R9: no ticks, no progress
        bit_tick = 1'b0;
        @(negedge clk);
        tx_busy = 1'b1;
        @(negedge clk);
        tx_busy = 1'b0;
        repeat (300) @(negedge clk);
        check("R9 stalled without ticks", int'(defer_ok), 0);

        // R9: random phase against the bench model
        do_reset();
        void'($urandom(32'd1234));
        for (int i = 0; i < 20000; i++) begin
            if (i % 2500 == 0) two_part_dis = ~two_part_dis;
            bit_tick = ($urandom % 3) != 0;
            crs = (crs && ($urandom % 4 != 0)) || ($urandom % 60 == 0);
            tx_busy = (tx_busy && ($urandom % 12 != 0)) || ($urandom % 400 == 0);
            model_step(crs, tx_busy, two_part_dis, bit_tick);
            @(negedge clk);
            checks++;
            if (defer_ok !== model_ok(tx_busy)) begin
                failures++;
                $display("FAIL R9 random cycle %0d actual=%0d expected=%0d",
                         i, defer_ok, model_ok(tx_busy));
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule